// File: doc/BRIEF.md
# Timer Target Compare Unit

This block watches a free-running 64-bit time value supplied from outside and raises a one-cycle event pulse when that value equals a programmed 64-bit target. Each event also sets a sticky interrupt status flag. The interrupt output is that flag gated by an enable bit.

After each event the block computes the next target by itself, so the host does not have to step in. In reload mode it takes a preset 64-bit reload value, which gives a one-shot trigger at a time the host chose in advance. In add mode it adds the low 32 bits of the reload register to the current target, which gives a periodic trigger.

The host writes the target and reload registers as two 32-bit halves. Each 64-bit register changes only once both halves have arrived. The time counter is outside the block: its value and a strobe that marks a host write to it come in as inputs.

Top module: `tgt_cmp_top`

## Requirements
- R1: When `time_val` equals the target at a rising clock edge and no hold applies, `evt_o` is high for the one cycle after that edge.
- R2: One match gives one event. If the next target equals the current one (add of 0, or reload of the same value), a counter that stays at the target produces no further event until it leaves the target or the target is rewritten.
- R3: An event sets `irq_sts_o` in the same cycle that `evt_o` is high. `irq_o` is high only while `irq_sts_o` is high and the enable bit (bit 1 of the config register, address 4) is 1.
- R4: Writing address 5 with bit 0 = 1 clears `irq_sts_o`. A write with bit 0 = 0 leaves it unchanged. If an event and a clear fall in the same cycle, the event wins and the flag stays set.
- R5: With the mode bit set to 1 (bit 0 of address 4), the target after an event is the full 64-bit reload register.
- R6: With the mode bit set to 0, the target after an event is the current target plus the zero-extended low 32 bits of the reload register. The reload high half has no effect in this mode.
- R7: Target arithmetic wraps modulo 2^64.
- R8: The target low/high halves are at addresses 0 and 1, and the reload low/high halves at addresses 2 and 3. A 64-bit register takes its new value only on the write that completes both halves, and the halves may be written in either order. A single half-write never changes what the block compares against.
- R9: A cycle with `time_wr` high and `time_val` equal to the target produces an event even while a hold from R2 applies.
- R10: Reset gives a target of all ones, a reload value of 0, mode 0, interrupts disabled, and `evt_o`, `irq_sts_o` and `irq_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_val | input | 64 | Current value of the time counter |
| time_wr | input | 1 | High in the cycle the host loads the time counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| evt_o | output | 1 | One-cycle compare event pulse |
| irq_sts_o | output | 1 | Sticky timer interrupt status |
| irq_o | output | 1 | Status gated by the interrupt enable |

## Verification
A wrong target register, whether from a bad next-target calculation, a lost wrap carry or a half committed too early, shows up as a missing or misplaced `evt_o` pulse. It appears one cycle after the counter reaches the time where the event should have occurred. A stale hold flag shows as a missing event or an extra one while the counter rests at the target. A broken status path shows on `irq_sts_o` or `irq_o` in the same cycle as the event, or at the first clear write.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADR_TGT_LO = 0;
  localparam int ADR_TGT_HI = 1;
  localparam int ADR_RLD_LO = 2;
  localparam int ADR_RLD_HI = 3;
  localparam int ADR_CFG    = 4;
  localparam int ADR_STS    = 5;
  localparam int CFG_MODE_BIT = 0;
  localparam int CFG_IEN_BIT  = 1;
  localparam int STS_CLR_BIT  = 0;
endpackage

// File: rtl/tcu_half_pair.sv
// Collects two half-width writes and commits the full value when both are present.
module tcu_half_pair #(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic          commit,
  output logic [2*HW-1:0] value
);
  logic [HW-1:0] sh_lo, sh_hi;
  logic          got_lo, got_hi;

  always_comb begin
    commit = (wr_lo & got_hi) | (wr_hi & got_lo);
    value  = wr_lo ? {sh_hi, wdata} : {wdata, sh_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_lo  <= '0;
      sh_hi  <= '0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (commit) begin
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else begin
      if (wr_lo) begin
        sh_lo  <= wdata;
        got_lo <= 1'b1;
      end
      if (wr_hi) begin
        sh_hi  <= wdata;
        got_hi <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcu_next.sv
// Next-target calculation: full reload or increment by the low part.
module tcu_next #(
  parameter int W  = 64,
  parameter int IW = 32
) (
  input  logic         mode,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] reload,
  output logic [W-1:0] nxt
);
  localparam int PADW = W - IW;
  assign nxt = mode ? reload : tgt + {{PADW{1'b0}}, reload[IW-1:0]};
endmodule

// File: rtl/tcu_fire.sv
// Equality compare with a hold flag that suppresses retriggering on an unchanged target.
module tcu_fire #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] time_val,
  input  logic         time_wr,
  input  logic [W-1:0] tgt,
  input  logic         tgt_load,
  input  logic         nxt_same,
  output logic         fire
);
  logic match, hold_q;

  assign match = (time_val == tgt);
  assign fire  = match & (~hold_q | time_wr);

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= 1'b0;
    else if (tgt_load) hold_q <= 1'b0;
    else if (fire)     hold_q <= nxt_same;
    else               hold_q <= hold_q & match;
  end
endmodule

// File: rtl/tgt_cmp_top.sv
module tgt_cmp_top
  import tcu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_val,
  input  logic          time_wr,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          evt_o,
  output logic          irq_sts_o,
  output logic          irq_o
);
  localparam logic [TW-1:0] RST_TGT = '1;

  logic          we_tlo, we_thi, we_rlo, we_rhi, we_cfg, we_sts;
  logic          tgt_commit, rld_commit, sts_clr, fire, nxt_same;
  logic [TW-1:0] tgt_wval, rld_wval, nxt;
  logic [TW-1:0] tgt_q, rld_q;
  logic          mode_q, ien_q, ien_n, sts_n;

  assign we_tlo = reg_we && (reg_addr == AW'(ADR_TGT_LO));
  assign we_thi = reg_we && (reg_addr == AW'(ADR_TGT_HI));
  assign we_rlo = reg_we && (reg_addr == AW'(ADR_RLD_LO));
  assign we_rhi = reg_we && (reg_addr == AW'(ADR_RLD_HI));
  assign we_cfg = reg_we && (reg_addr == AW'(ADR_CFG));
  assign we_sts = reg_we && (reg_addr == AW'(ADR_STS));
  assign sts_clr = we_sts & reg_wdata[STS_CLR_BIT];

  tcu_half_pair #(.HW(DW)) u_tgt_pair (
    .clk(clk), .rst(rst), .wr_lo(we_tlo), .wr_hi(we_thi), .wdata(reg_wdata),
    .commit(tgt_commit), .value(tgt_wval)
  );

  tcu_half_pair #(.HW(DW)) u_rld_pair (
    .clk(clk), .rst(rst), .wr_lo(we_rlo), .wr_hi(we_rhi), .wdata(reg_wdata),
    .commit(rld_commit), .value(rld_wval)
  );

  tcu_next #(.W(TW), .IW(DW)) u_next (
    .mode(mode_q), .tgt(tgt_q), .reload(rld_q), .nxt(nxt)
  );

  assign nxt_same = (nxt == tgt_q);

  tcu_fire #(.W(TW)) u_fire (
    .clk(clk), .rst(rst), .time_val(time_val), .time_wr(time_wr),
    .tgt(tgt_q), .tgt_load(tgt_commit), .nxt_same(nxt_same), .fire(fire)
  );

  assign sts_n = fire | (irq_sts_o & ~sts_clr);
  assign ien_n = we_cfg ? reg_wdata[CFG_IEN_BIT] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q     <= RST_TGT;
      rld_q     <= '0;
      mode_q    <= 1'b0;
      ien_q     <= 1'b0;
      evt_o     <= 1'b0;
      irq_sts_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      evt_o     <= fire;
      irq_sts_o <= sts_n;
      irq_o     <= sts_n & ien_n;
      ien_q     <= ien_n;
      if (we_cfg) mode_q <= reg_wdata[CFG_MODE_BIT];
      if (tgt_commit)  tgt_q <= tgt_wval;
      else if (fire)   tgt_q <= nxt;
      if (rld_commit)  rld_q <= rld_wval;
    end
  end
endmodule

// File: rtl/tcu_chk.sv
module tcu_chk
  import tcu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int TW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] time_val,
  input logic [TW-1:0] tgt_q,
  input logic [TW-1:0] rld_q,
  input logic          mode_q,
  input logic          ien_q,
  input logic          fire,
  input logic          tgt_commit,
  input logic          evt_o,
  input logic          irq_sts_o,
  input logic          irq_o,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == AW'(ADR_STS)) && reg_wdata[STS_CLR_BIT];

  assert_evt_on_match_R1: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(time_val == tgt_q));

  assert_sts_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sts_o) |-> evt_o);

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_sts_o && ien_q));

  assert_sts_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_sts_o && !clr_wr) |=> irq_sts_o);

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && !tgt_commit && mode_q) |=> (tgt_q == $past(rld_q)));

  assert_add_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && !tgt_commit && !mode_q) |=>
      (tgt_q == $past(tgt_q) + TW'($past(rld_q[DW-1:0]))));
endmodule

bind tgt_cmp_top tcu_chk #(.DW(DW), .AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .time_val(time_val), .tgt_q(tgt_q), .rld_q(rld_q),
  .mode_q(mode_q), .ien_q(ien_q), .fire(fire), .tgt_commit(tgt_commit),
  .evt_o(evt_o), .irq_sts_o(irq_sts_o), .irq_o(irq_o), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_tgt_cmp_top.sv
`timescale 1ns/1ps
module sim_tgt_cmp_top;
  localparam logic [63:0] PARK = 64'h0F0F_0000_1111_2222;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_val = '0;
  logic        time_wr = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        evt_o, irq_sts_o, irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tgt_cmp_top u0 (
    .clk(clk), .rst(rst), .time_val(time_val), .time_wr(time_wr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .evt_o(evt_o), .irq_sts_o(irq_sts_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] exp_next(input logic md, input logic [63:0] t,
                                           input logic [63:0] r);
    return md ? r : t + {32'd0, r[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_tgt(input logic [63:0] v);
    wr(0, v[31:0]); wr(1, v[63:32]);
  endtask

  task automatic set_rld(input logic [63:0] v);
    wr(2, v[31:0]); wr(3, v[63:32]);
  endtask

  task automatic count_evts(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (evt_o) c++;
    end
  endtask

  task automatic hit(input logic [63:0] t, input string req);
    time_val = t;
    @(negedge clk);
    check(evt_o === 1'b1, req, 64'(evt_o), 64'd1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    logic [63:0] t, r, nx;
    logic md;
    void'($urandom(32'd1588));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(evt_o === 1'b0 && irq_sts_o === 1'b0 && irq_o === 1'b0, "R10 reset outputs",
          {61'd0, evt_o, irq_sts_o, irq_o}, 64'd0);
    hit(64'hFFFF_FFFF_FFFF_FFFF, "R10 reset target all ones");
    check(irq_sts_o === 1'b1 && irq_o === 1'b0, "R10 irq disabled after reset",
          {62'd0, irq_sts_o, irq_o}, 64'd2);
    // R2: held at unchanged target, no retrigger
    count_evts(4, c);
    check(c == 0, "R2 no retrigger at held target", 64'(c), 64'd0);
    time_val = PARK;
    wr(5, 32'h0);
    check(irq_sts_o === 1'b1, "R4 write of 0 keeps status", 64'(irq_sts_o), 64'd1);
    wr(5, 32'h1);
    check(irq_sts_o === 1'b0, "R4 clear", 64'(irq_sts_o), 64'd0);

    // R6 add mode with enable, reload high ignored
    wr(4, 32'h2);
    set_rld(64'hDEAD_BEEF_0000_0010);
    set_tgt(64'd100);
    time_val = 64'd99;
    count_evts(2, c);
    check(c == 0, "R1 no event before target", 64'(c), 64'd0);
    hit(64'd100, "R1 event on equality");
    check(irq_o === 1'b1 && irq_sts_o === 1'b1, "R3 irq with enable",
          {62'd0, irq_sts_o, irq_o}, 64'd3);
    time_val = 64'd101;
    count_evts(3, c);
    check(c == 0, "R6 no event off target", 64'(c), 64'd0);
    hit(64'd116, "R6 add of low 32 bits");
    count_evts(3, c);
    check(c == 0, "R2 single event while counter held", 64'(c), 64'd0);
    // R4 set wins over clear in same cycle (target now 132)
    time_val = 64'd132;
    wr(5, 32'h1);
    check(evt_o === 1'b1 && irq_sts_o === 1'b1, "R4 set wins over clear",
          {62'd0, evt_o, irq_sts_o}, 64'd3);
    wr(5, 32'h1);
    check(irq_sts_o === 1'b0 && irq_o === 1'b0, "R4 clear after event",
          {62'd0, irq_sts_o, irq_o}, 64'd0);
    // R3 enable off: status set, irq low (target now 148)
    wr(4, 32'h0);
    hit(64'd148, "R3 event with irq disabled");
    check(irq_sts_o === 1'b1 && irq_o === 1'b0, "R3 irq gated by enable",
          {62'd0, irq_sts_o, irq_o}, 64'd2);

    // R5 reload mode, then R2 hold and R9 time write
    time_val = PARK;
    wr(4, 32'h3);
    set_rld(64'h0000_0042_0000_9000);
    set_tgt(64'h0000_0001_0000_0500);
    hit(64'h0000_0001_0000_0500, "R5 first target");
    hit(64'h0000_0042_0000_9000, "R5 reload target");
    count_evts(3, c);
    check(c == 0, "R2 reload of same value holds", 64'(c), 64'd0);
    time_wr = 1'b1;
    @(negedge clk);
    time_wr = 1'b0;
    check(evt_o === 1'b1, "R9 time write equal to target fires", 64'(evt_o), 64'd1);

    // R7 wrap
    time_val = PARK;
    wr(4, 32'h0);
    set_rld(64'h0000_0000_0000_000A);
    set_tgt(64'hFFFF_FFFF_FFFF_FFFC);
    hit(64'hFFFF_FFFF_FFFF_FFFC, "R7 target near top");
    hit(64'd6, "R7 wrap past zero");

    // R8 half writes, low first then high
    time_val = 64'h0000_0077_0000_1234;
    wr(0, 32'h0000_1234);
    time_val = 64'h0000_0000_0000_1234;
    count_evts(3, c);
    check(c == 0, "R8 low half alone not committed", 64'(c), 64'd0);
    time_val = 64'h0000_0077_0000_1234;
    count_evts(2, c);
    check(c == 0, "R8 no event before high half", 64'(c), 64'd0);
    wr(1, 32'h0000_0077);
    @(negedge clk);
    check(evt_o === 1'b1, "R8 commit after both halves", 64'(evt_o), 64'd1);
    // high first then low
    time_val = 64'h0000_0099_0000_0ABC;
    wr(1, 32'h0000_0099);
    count_evts(3, c);
    check(c == 0, "R8 high half alone not committed", 64'(c), 64'd0);
    wr(0, 32'h0000_0ABC);
    @(negedge clk);
    check(evt_o === 1'b1, "R8 commit in reverse order", 64'(evt_o), 64'd1);

    // random mix R1 R5 R6
    for (int k = 0; k < 24; k++) begin
      md = 1'($urandom);
      t  = {$urandom, $urandom};
      r  = {$urandom, $urandom};
      time_val = PARK;
      wr(4, {30'd0, 1'b1, md});
      set_rld(r);
      set_tgt(t);
      hit(t, "R1 random target");
      nx = exp_next(md, t, r);
      if (nx != t && nx != PARK) hit(nx, md ? "R5 random reload" : "R6 random add");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule